// File: doc/BRIEF.md
# Host and PCI Master Bus Arbiter

This block decides who owns a shared PCI bus: the host CPU or one of five PCI masters. Masters ask through active-low request lines, the CPU through an active-high request. The block watches FRAME# and IRDY# to see when the bus is idle, and it returns one grant at a time: active-low grants to the masters and an active-high grant to the CPU. A debug output reports the current owner.

Ownership changes only while the bus is idle. Between two owners there is always exactly one clock with no grant. A static configuration input sets the arbitration policy:
- whether masters take priority over the CPU, or the two sides alternate;
- whether the current master releases the bus when its request drops or after its FRAME# has been seen;
- how often the CPU must get the bus, counted in master grants;
- which master request may be promoted to high priority;
- whether a newly granted CPU keeps the bus for a guaranteed extra clock;
- a tenure limit, in units of 32 clocks, for masters that hold on to the bus.

With no request pending, the grant parks on the CPU.

Top module: `hostpci_arbiter`

## Requirements
- R1: At most one of the six grants (`gnt_n` low bits and `cpu_gnt`) is active in any clock. `owner_o` always agrees with the active grant.
- R2: `owner_o` is 0 to 4 for a master, 5 for the CPU and 7 while no grant is driven. A grant is only removed in a clock where `frame_n` and `irdy_n` are both high. A removed grant is followed by exactly one clock with no grant before the next owner is granted.
- R3: Reset is synchronous and active-high. It parks the grant on the CPU and clears the master-grant count, the tenure counter and the round-robin pointer, so that master 0 is searched first. Whenever a grant is handed out and no master is requesting, it goes to the CPU.
- R4: With `cfg_frame_pt`=0, a master keeps the bus while its request stays low, whatever FRAME# does. It gives the bus up at the first idle clock after its request goes high.
- R5: With `cfg_frame_pt`=1, a master is re-arbitrated at the first idle clock after FRAME# has been low during its tenure, even while its request stays low.
- R6: Among ordinary masters, the winner is the first requester found when counting upward (wrapping after 4) from the master granted most recently.
- R7: With `cfg_fair`=0, a requesting master wins over a requesting CPU, and a requesting master takes the bus from the CPU.
- R8: With `cfg_fair`=1, a requesting CPU wins the hand-off right after a master tenure, and masters win the hand-off right after a CPU tenure.
- R9: With `cfg_cpu_noslot`=0, a granted CPU keeps its grant for at least two clocks. With `cfg_cpu_noslot`=1, the grant may be removed after one clock.
- R10: With `cfg_rot`=K (K = 1, 2 or 3), a requesting CPU is granted once K master grants have been given since its last requested grant, even if masters are still requesting. With `cfg_rot`=0 this rule is off.
- R11: With `cfg_hp_en`=1, the master chosen by `cfg_hp_sel` wins over all other masters whenever it requests. The mapping is 00 to master 4, 01 to master 0, 10 to master 1 and 11 to master 2. With `cfg_hp_en`=0 the promotion has no effect.
- R12: With `cfg_tmo`=N, where N is not 0, a master that still requests loses the grant after N×32 clocks of tenure on an idle bus. With N=0 there is no limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_n | input | 5 | Active-low master requests, bit i for master i |
| frame_n | input | 1 | Bus FRAME#, active low |
| irdy_n | input | 1 | Bus IRDY#, active low |
| cpu_req | input | 1 | CPU bus request, active high |
| cfg_fair | input | 1 | 0: masters first, 1: alternate CPU and masters |
| cfg_frame_pt | input | 1 | 0: release on request drop, 1: release after FRAME# |
| cfg_rot | input | 2 | CPU guarantee after 1, 2 or 3 master grants, 0 off |
| cfg_tmo | input | 4 | Master tenure limit in units of 32 clocks, 0 off |
| cfg_hp_sel | input | 2 | Which master is promoted |
| cfg_hp_en | input | 1 | Enables the promotion |
| cfg_cpu_noslot | input | 1 | 1 removes the CPU's guaranteed extra clock |
| gnt_n | output | 5 | Active-low master grants |
| cpu_gnt | output | 1 | CPU grant, active high |
| owner_o | output | 3 | Debug owner code (0 to 4 master, 5 CPU, 7 none) |

## Verification
The hardest case to reach is a rotation-forced CPU grant. It needs several master tenures to end back to back while other masters keep requesting, so that the master-grant count climbs to the configured limit. The stimulus gets there by raising the current owner's request for exactly one clock. That clock is the hand-off gap, and the request is lowered again in the same gap, so the bus never runs out of requesters. The bench then checks whether the CPU or another master takes the next tenure. The tenure limit is checked the same way: the clock counted from the grant edge at which the limit is reached is worked out in advance.

// File: rtl/hostpci_arb_pkg.sv
`timescale 1ns/1ps
package hostpci_arb_pkg;

    localparam int NUM_M    = 5;          // PCI masters
    localparam int IDX_W    = 3;          // owner code width
    localparam int ROT_W    = 2;          // CPU rotation field
    localparam int TMO_W    = 4;          // tenure limit field
    localparam int UNIT_SH  = 5;          // limit unit = 2**UNIT_SH clocks
    localparam int HPSEL_W  = 2;

    typedef logic [IDX_W-1:0] own_t;

    localparam own_t OWN_CPU  = own_t'(5);
    localparam own_t OWN_NONE = own_t'(7);

    typedef enum logic [0:0] {
        ST_OWN = 1'b0,   // a grant is driven
        ST_GAP = 1'b1    // idle turnaround clock, no grant
    } arb_st_e;

    typedef struct packed {
        logic               fair;
        logic               frame_pt;
        logic [ROT_W-1:0]   rot;
        logic [TMO_W-1:0]   tmo;
        logic [HPSEL_W-1:0] hp_sel;
        logic               hp_en;
        logic               cpu_noslot;
    } arb_cfg_t;

    // Promoted master for each selector value.
    function automatic own_t hp_index(input logic [HPSEL_W-1:0] sel);
        own_t r;
        case (sel)
            2'b00:   r = own_t'(4);
            2'b01:   r = own_t'(0);
            2'b10:   r = own_t'(1);
            default: r = own_t'(2);
        endcase
        return r;
    endfunction

    // First requester found counting upward from the one after 'last'.
    function automatic own_t rr_pick(input logic [NUM_M-1:0] req,
                                     input own_t last);
        own_t pick;
        pick = last;
        for (int k = NUM_M; k >= 1; k--) begin
            own_t cand;
            cand = own_t'((int'(last) + k) % NUM_M);
            if (req[cand]) pick = cand;
        end
        return pick;
    endfunction

endpackage

// File: rtl/hostpci_arb_tenure.sv
`timescale 1ns/1ps
module hostpci_arb_tenure
    import hostpci_arb_pkg::*;
#(
    parameter int LIM_W  = TMO_W,
    parameter int SHIFT  = UNIT_SH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,     // turnaround clock: next clock starts a tenure
    input  logic             frame_n,
    input  logic [LIM_W-1:0] tmo_units,
    output logic             slot_done,   // at least one full clock of tenure elapsed
    output logic             tmo_hit,     // tenure reached the limit
    output logic             frame_seen   // FRAME# observed low during tenure
);
    localparam int CNT_W = LIM_W + SHIFT + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             seen_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            seen_q <= 1'b0;
        end else if (!frame_n) begin
            seen_q <= 1'b1;
        end
    end

    // Tenure clocks are numbered from 0, so the last allowed one is N*32-1.
    assign limit      = {1'b0, tmo_units, {SHIFT{1'b0}}} - CNT_W'(1);
    assign tmo_hit    = (tmo_units != '0) && (cnt_q >= limit);
    assign slot_done  = (cnt_q != '0);
    assign frame_seen = seen_q;

endmodule

// File: rtl/hostpci_arb_rotation.sv
`timescale 1ns/1ps
module hostpci_arb_rotation
    import hostpci_arb_pkg::*;
#(
    parameter int CW = ROT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          grant_evt,   // a grant is issued at this edge
    input  logic          to_cpu,      // that grant goes to the CPU
    input  logic          cpu_req,
    output logic [CW-1:0] mgrants      // master grants since the CPU's last served request
);
    localparam logic [CW-1:0] SAT = '1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (grant_evt) begin
            if (to_cpu) begin
                if (cpu_req) cnt_q <= '0;         // parking does not serve the CPU
            end else if (cnt_q != SAT) begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    assign mgrants = cnt_q;

endmodule

// File: rtl/hostpci_arb_select.sv
`timescale 1ns/1ps
module hostpci_arb_select
    import hostpci_arb_pkg::*;
(
    input  arb_cfg_t         cfg,
    input  logic [NUM_M-1:0] req,        // active-high master requests
    input  logic             cpu_req,
    input  own_t             last_m,     // most recently granted master
    input  logic             last_was_m, // previous tenure belonged to a master
    input  logic [ROT_W-1:0] mgrants,
    output own_t             win
);
    own_t hp_i;
    logic any_m;
    logic hp_hit;
    logic force_cpu;
    logic fair_cpu;

    always_comb begin
        hp_i      = hp_index(cfg.hp_sel);
        any_m     = |req;
        hp_hit    = cfg.hp_en && req[hp_i];
        force_cpu = (cfg.rot != '0) && (mgrants >= cfg.rot);
        fair_cpu  = cfg.fair && last_was_m;

        if (!any_m) begin
            win = OWN_CPU;                        // park (or serve) the CPU
        end else if (cpu_req && (force_cpu || fair_cpu)) begin
            win = OWN_CPU;
        end else if (hp_hit) begin
            win = hp_i;
        end else begin
            win = rr_pick(req, last_m);
        end
    end

endmodule

// File: rtl/hostpci_arbiter.sv
`timescale 1ns/1ps
module hostpci_arbiter
    import hostpci_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_M-1:0]   req_n,
    input  logic               frame_n,
    input  logic               irdy_n,
    input  logic               cpu_req,
    input  logic               cfg_fair,
    input  logic               cfg_frame_pt,
    input  logic [ROT_W-1:0]   cfg_rot,
    input  logic [TMO_W-1:0]   cfg_tmo,
    input  logic [HPSEL_W-1:0] cfg_hp_sel,
    input  logic               cfg_hp_en,
    input  logic               cfg_cpu_noslot,
    output logic [NUM_M-1:0]   gnt_n,
    output logic               cpu_gnt,
    output logic [IDX_W-1:0]   owner_o
);
    localparam int PAD_N = 1 << IDX_W;

    arb_cfg_t cfg;
    arb_st_e  st_q;
    own_t     owner_q;
    own_t     last_m_q;
    logic     last_was_m_q;

    logic [NUM_M-1:0] req_act;
    logic [PAD_N-1:0] req_pad;
    logic             own_req_n;
    logic             bus_idle;
    logic             owner_is_cpu;
    logic             m_release;
    logic             cpu_release;
    logic             release_now;
    logic             in_gap;
    own_t             win;
    logic [ROT_W-1:0] mgrants;
    logic             slot_done;
    logic             tmo_hit;
    logic             frame_seen;

    assign cfg = '{fair:       cfg_fair,
                   frame_pt:   cfg_frame_pt,
                   rot:        cfg_rot,
                   tmo:        cfg_tmo,
                   hp_sel:     cfg_hp_sel,
                   hp_en:      cfg_hp_en,
                   cpu_noslot: cfg_cpu_noslot};

    assign req_act = ~req_n;
    assign req_pad = {{(PAD_N-NUM_M){1'b1}}, req_n};
    assign in_gap  = (st_q == ST_GAP);

    hostpci_arb_select u_sel (
        .cfg        (cfg),
        .req        (req_act),
        .cpu_req    (cpu_req),
        .last_m     (last_m_q),
        .last_was_m (last_was_m_q),
        .mgrants    (mgrants),
        .win        (win)
    );

    hostpci_arb_rotation #(.CW(ROT_W)) u_rot (
        .clk       (clk),
        .rst       (rst),
        .grant_evt (in_gap),
        .to_cpu    (win == OWN_CPU),
        .cpu_req   (cpu_req),
        .mgrants   (mgrants)
    );

    hostpci_arb_tenure #(.LIM_W(TMO_W), .SHIFT(UNIT_SH)) u_ten (
        .clk        (clk),
        .rst        (rst),
        .restart    (in_gap),
        .frame_n    (frame_n),
        .tmo_units  (cfg.tmo),
        .slot_done  (slot_done),
        .tmo_hit    (tmo_hit),
        .frame_seen (frame_seen)
    );

    // Release decision for the current owner.
    assign bus_idle     = frame_n && irdy_n;
    assign owner_is_cpu = (owner_q == OWN_CPU);
    assign own_req_n    = req_pad[owner_q];
    assign m_release    = own_req_n || (cfg.frame_pt && frame_seen) || tmo_hit;
    assign cpu_release  = (slot_done || cfg.cpu_noslot) && (|req_act);
    assign release_now  = bus_idle && (owner_is_cpu ? cpu_release : m_release);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= ST_OWN;
            owner_q      <= OWN_CPU;
            last_m_q     <= own_t'(NUM_M - 1);
            last_was_m_q <= 1'b0;
        end else if (st_q == ST_OWN) begin
            if (release_now) begin
                st_q         <= ST_GAP;
                last_was_m_q <= !owner_is_cpu;
                if (!owner_is_cpu) last_m_q <= owner_q;
            end
        end else begin
            st_q    <= ST_OWN;
            owner_q <= win;
        end
    end

    for (genvar g = 0; g < NUM_M; g++) begin : g_gnt
        assign gnt_n[g] = !((st_q == ST_OWN) && (owner_q == own_t'(g)));
    end

    assign cpu_gnt = (st_q == ST_OWN) && owner_is_cpu;
    assign owner_o = in_gap ? OWN_NONE : owner_q;

endmodule

// File: rtl/hostpci_arbiter_chk.sv
`timescale 1ns/1ps
module hostpci_arbiter_chk
    import hostpci_arb_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [NUM_M-1:0] req_n,
    input logic             frame_n,
    input logic             irdy_n,
    input logic [NUM_M-1:0] gnt_n,
    input logic             cpu_gnt,
    input logic [IDX_W-1:0] owner_o
);
    a_r1_onehot_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0({~gnt_n, cpu_gnt}));

    a_r1_owner_cpu: assert property (@(posedge clk) disable iff (rst)
        (owner_o == OWN_CPU) |-> (cpu_gnt && (&gnt_n)));

    a_r2_busy_hold: assert property (@(posedge clk) disable iff (rst)
        ((owner_o != OWN_NONE) && !(frame_n && irdy_n)) |=> (owner_o == $past(owner_o)));

    a_r2_no_direct_swap: assert property (@(posedge clk) disable iff (rst)
        (owner_o != OWN_NONE) |=> ((owner_o == $past(owner_o)) || (owner_o == OWN_NONE)));

    a_r2_single_gap: assert property (@(posedge clk) disable iff (rst)
        (owner_o == OWN_NONE) |=> (owner_o != OWN_NONE));

    a_r3_park_cpu: assert property (@(posedge clk) disable iff (rst)
        ((owner_o == OWN_NONE) && (&req_n)) |=> cpu_gnt);

    a_r3_reset_park: assert property (@(posedge clk)
        rst |=> (cpu_gnt && (owner_o == OWN_CPU)));

endmodule

bind hostpci_arbiter hostpci_arbiter_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .req_n   (req_n),
    .frame_n (frame_n),
    .irdy_n  (irdy_n),
    .gnt_n   (gnt_n),
    .cpu_gnt (cpu_gnt),
    .owner_o (owner_o)
);

// File: tb/hostpci_arbiter_tb_top.sv
`timescale 1ns/1ps
module hostpci_arbiter_tb_top;
    import hostpci_arb_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] req_n = '1;
    logic       frame_n = 1'b1, irdy_n = 1'b1, cpu_req = 1'b0;
    logic       cfg_fair = 1'b0, cfg_frame_pt = 1'b0, cfg_hp_en = 1'b0, cfg_cpu_noslot = 1'b0;
    logic [1:0] cfg_rot = '0, cfg_hp_sel = '0;
    logic [3:0] cfg_tmo = '0;
    logic [4:0] gnt_n;
    logic       cpu_gnt;
    logic [2:0] owner_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    hostpci_arbiter dut_i (
        .clk(clk), .rst(rst), .req_n(req_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .cpu_req(cpu_req), .cfg_fair(cfg_fair), .cfg_frame_pt(cfg_frame_pt),
        .cfg_rot(cfg_rot), .cfg_tmo(cfg_tmo), .cfg_hp_sel(cfg_hp_sel),
        .cfg_hp_en(cfg_hp_en), .cfg_cpu_noslot(cfg_cpu_noslot),
        .gnt_n(gnt_n), .cpu_gnt(cpu_gnt), .owner_o(owner_o)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Checks owner code and the full grant pattern implied by it (R1).
    task automatic check_owner(input logic [2:0] exp, input string tag);
        logic [4:0] exp_gnt;
        logic       exp_cpu;
        exp_gnt = '1;
        for (int i = 0; i < NUM_M; i++) if (exp == 3'(i)) exp_gnt[i] = 1'b0;
        exp_cpu = (exp == 3'd5);
        n_checks++;
        if (owner_o !== exp || gnt_n !== exp_gnt || cpu_gnt !== exp_cpu) begin
            n_fail++;
            $display("FAIL %s (R1 grants): owner=%0d gnt_n=%b cpu_gnt=%b, expected owner=%0d gnt_n=%b cpu_gnt=%b",
                     tag, owner_o, gnt_n, cpu_gnt, exp, exp_gnt, exp_cpu);
        end
    endtask

    task automatic reset_dut();
        rst = 1'b1; req_n = '1; frame_n = 1'b1; irdy_n = 1'b1; cpu_req = 1'b0;
        cfg_fair = 1'b0; cfg_frame_pt = 1'b0; cfg_rot = '0; cfg_tmo = '0;
        cfg_hp_sel = '0; cfg_hp_en = 1'b0; cfg_cpu_noslot = 1'b0;
        step(3);
        rst = 1'b0;
        step(2);
    endtask

    // Owner raises its request for exactly the turnaround clock.
    task automatic bounce(input int m, input string tag);
        req_n[m] = 1'b1;
        step(1);
        check_owner(3'd7, tag);
        req_n[m] = 1'b0;
        step(1);
    endtask

    task automatic t_reset();
        reset_dut();
        check_owner(3'd5, "R3 reset parks on CPU");
        step(4);
        check_owner(3'd5, "R3 parked with no requests");
    endtask

    task automatic t_roundrobin();
        reset_dut();
        req_n = 5'b11011;                       // master 2
        step(1); check_owner(3'd7, "R2 gap after CPU");
        step(1); check_owner(3'd2, "R6 first master granted");
        req_n = 5'b01010;                       // 0, 2, 4
        step(3); check_owner(3'd2, "R4 hold while request low");
        req_n = 5'b01110;                       // 2 drops
        step(1); check_owner(3'd7, "R4 release on request drop");
        step(1); check_owner(3'd4, "R6 next after 2 is 4");
        req_n = 5'b11110;
        step(2); check_owner(3'd0, "R6 wrap to 0");
        req_n = 5'b11111;
        step(2); check_owner(3'd5, "R3 park after last master");
    endtask

    task automatic t_busy();
        reset_dut();
        req_n = 5'b11101;
        step(2); check_owner(3'd1, "R2 master 1 granted");
        frame_n = 1'b0; req_n = '1;
        step(3); check_owner(3'd1, "R2 hold while FRAME low");
        frame_n = 1'b1; irdy_n = 1'b0;
        step(2); check_owner(3'd1, "R2 hold while IRDY low");
        irdy_n = 1'b1;
        step(1); check_owner(3'd7, "R2 gap once idle");
        step(1); check_owner(3'd5, "R3 park");
    endtask

    task automatic t_policy();
        reset_dut();
        cpu_req = 1'b1;
        req_n = 5'b10111;                       // master 3
        step(1); check_owner(3'd7, "R7 CPU preempted");
        step(1); check_owner(3'd3, "R7 master beats CPU");
        req_n = '1;
        step(2); check_owner(3'd5, "R7 CPU after masters");
        cfg_fair = 1'b1;
        req_n = 5'b11100;                       // 0 and 1
        step(1); check_owner(3'd5, "R9 CPU keeps slot clock");
        step(1); check_owner(3'd7, "R9 gap after slot");
        step(1); check_owner(3'd0, "R8 master after CPU tenure");
        req_n = 5'b11101;                       // 0 drops, 1 remains
        step(2); check_owner(3'd5, "R8 CPU after master tenure");
        step(1); check_owner(3'd5, "R9 slot held again");
        step(2); check_owner(3'd1, "R8 master 1 after CPU");
        cfg_cpu_noslot = 1'b1;
        req_n = 5'b11110;                       // 1 drops, 0 remains
        step(2); check_owner(3'd5, "R8 CPU again");
        step(1); check_owner(3'd7, "R9 no slot: removed after one clock");
        step(1); check_owner(3'd0, "R9 master 0 follows");
    endtask

    task automatic t_rotation();
        reset_dut();
        cfg_rot = 2'b01; cpu_req = 1'b1;
        req_n = 5'b11000;                       // 0, 1, 2
        step(2); check_owner(3'd0, "R10 first master");
        bounce(0, "R10 gap");
        check_owner(3'd5, "R10 rot=1 CPU after one master grant");
        step(1); check_owner(3'd5, "R9 CPU slot");
        step(2); check_owner(3'd1, "R10 masters resume");

        reset_dut();
        cfg_rot = 2'b11; cpu_req = 1'b1;
        req_n = 5'b11000;
        step(2); check_owner(3'd0, "R10 rot=3 grant 1");
        bounce(0, "R10 gap");
        check_owner(3'd1, "R10 rot=3 grant 2");
        bounce(1, "R10 gap");
        check_owner(3'd2, "R10 rot=3 grant 3");
        bounce(2, "R10 gap");
        check_owner(3'd5, "R10 rot=3 CPU forced");

        reset_dut();
        cpu_req = 1'b1;
        req_n = 5'b11000;
        step(2);
        bounce(0, "R10 gap"); bounce(1, "R10 gap"); bounce(2, "R10 gap");
        check_owner(3'd0, "R10 rot=0 CPU not forced");
    endtask

    task automatic t_highpri();
        reset_dut();
        cfg_hp_en = 1'b1; cfg_hp_sel = 2'b00;   // master 4
        req_n = 5'b01101;                       // 1 and 4
        step(2); check_owner(3'd4, "R11 sel 00 promotes 4");
        bounce(4, "R11 gap");
        check_owner(3'd4, "R11 promoted wins again");
        cfg_hp_en = 1'b0;
        bounce(4, "R11 gap");
        check_owner(3'd1, "R11 disabled: round-robin");

        reset_dut();
        cfg_hp_en = 1'b1; cfg_hp_sel = 2'b11;   // master 2
        req_n = 5'b11010;                       // 0 and 2
        step(2); check_owner(3'd2, "R11 sel 11 promotes 2");

        reset_dut();
        cfg_hp_en = 1'b1; cfg_hp_sel = 2'b10;   // master 1
        req_n = 5'b11100;                       // 0 and 1
        step(2); check_owner(3'd1, "R11 sel 10 promotes 1");
    endtask

    task automatic t_timeout();
        reset_dut();
        cfg_tmo = 4'd1;
        req_n = 5'b00111;                       // 3 and 4
        step(2); check_owner(3'd3, "R12 master 3 granted");
        step(31); check_owner(3'd3, "R12 held for 32 clocks");
        step(1); check_owner(3'd7, "R12 limit reached");
        step(1); check_owner(3'd4, "R12 next master");

        reset_dut();
        req_n = 5'b10111;
        step(2);
        step(100); check_owner(3'd3, "R12 limit off keeps owner");
    endtask

    task automatic t_framept();
        reset_dut();
        cfg_frame_pt = 1'b1;
        req_n = 5'b11010;                       // 0 and 2
        step(2); check_owner(3'd0, "R5 master 0 granted");
        frame_n = 1'b0;
        step(1); check_owner(3'd0, "R5 held during FRAME");
        frame_n = 1'b1;
        step(1); check_owner(3'd7, "R5 rearbitrate after FRAME");
        step(1); check_owner(3'd2, "R5 master 2 next");

        reset_dut();
        req_n = 5'b11010;
        step(2);
        frame_n = 1'b0; step(1); frame_n = 1'b1;
        step(3); check_owner(3'd0, "R4 FRAME ignored in request mode");
    endtask

    initial begin
        t_reset();
        t_roundrobin();
        t_busy();
        t_policy();
        t_rotation();
        t_highpri();
        t_timeout();
        t_framept();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R2: run still active, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule